// File: doc/BRIEF.md
# Two-Heading Intersection Signal Controller

This block drives the lamps of a crossroads with two headings (north-south and east-west). One four-phase sequencer serves both headings in turn. A one-bit heading flag selects which heading currently runs, and the other heading is held at red. A single countdown timer is shared by every phase. The sequencer reloads it with either a green period or a yellow period, both given in clock cycles as parameters.

Each heading has one traffic-sense input. Upstream logic must already have combined that heading's detectors into this one signal. When the green time of the running heading ends, a one-cycle decision phase looks at that heading's sense input only. If traffic is still present, the heading keeps green for one more yellow-length period before it goes to yellow. When yellow ends, the heading flag toggles and the other heading gets green.

The reset input is asynchronous and active-low. Its release passes through a two-stage synchronizer, so the sequencer starts two clock edges after `rst_n` rises.

Top module: `xing_light_ctrl`

## Requirements
- R1: While reset is held, and for the first YELLOW_TICKS cycles after the internal reset releases, heading 1 shows red and heading 2 shows yellow.
- R2: The yellow phase lasts exactly YELLOW_TICKS cycles. Both periods must be at least 2 cycles. When yellow ends, the active heading swaps and the newly active heading shows green.
- R3: The green phase shows green for GREEN_TICKS cycles. One decision cycle follows, during which green stays lit.
- R4: In the decision cycle, a high sense input on the active heading leads to the extension phase. A low sense input leads to the yellow phase.
- R5: The extension phase keeps green on for YELLOW_TICKS cycles and then goes to yellow.
- R6: Exactly one heading shows red at any time, namely the inactive one. The sense input of the inactive heading has no effect on the lamps.
- R7: Each heading has exactly one lamp lit in every cycle.
- R8: Pulling `rst_n` low in mid-run returns the lamps to the R1 pattern at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_h1 | input | 1 | Combined traffic-sense input, heading 1 |
| sense_h2 | input | 1 | Combined traffic-sense input, heading 2 |
| h1_red | output | 1 | Heading 1 red lamp |
| h1_amber | output | 1 | Heading 1 yellow lamp |
| h1_green | output | 1 | Heading 1 green lamp |
| h2_red | output | 1 | Heading 2 red lamp |
| h2_amber | output | 1 | Heading 2 yellow lamp |
| h2_green | output | 1 | Heading 2 green lamp |

## Verification
A wrong phase or a wrong heading flag shows up on the lamp outputs in the same cycle, because the lamps are decoded straight from those two registers. A timer that is off by even one count moves a lamp change by one cycle. The bench therefore compares all six lamps against an arithmetic cycle model on every cycle. Each sense pattern drives the decision cycle down both branches, and the bench also drives the inactive heading's sense input, so a wrongly selected sense input changes the lamps within one phase.

// File: rtl/tlc_pkg.sv
`timescale 1ns/1ps
package tlc_pkg;
  typedef enum logic [1:0] {
    PH_AMBER  = 2'd0,
    PH_GO     = 2'd1,
    PH_DECIDE = 2'd2,
    PH_EXTEND = 2'd3
  } phase_e;

  typedef struct packed {
    logic red;
    logic amber;
    logic green;
  } lamp_t;
endpackage

// File: rtl/tlc_timer.sv
`timescale 1ns/1ps
module tlc_timer #(
  parameter int GREEN_TICKS  = 16,
  parameter int YELLOW_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic pick_green,
  output logic expire
);
  localparam int MAX_TICKS = (GREEN_TICKS > YELLOW_TICKS) ? GREEN_TICKS : YELLOW_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Count down to zero and idle there until the sequencer reloads.
  always_comb begin
    cnt_en = load | (cnt_q != '0);
    if (load) cnt_d = pick_green ? CNT_W'(GREEN_TICKS) : CNT_W'(YELLOW_TICKS);
    else      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(YELLOW_TICKS);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire = (cnt_q == CNT_W'(1));

  // With both periods at least two, an expiry never repeats back to back.
  assert_expire_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/tlc_sequencer.sv
`timescale 1ns/1ps
module tlc_sequencer
  import tlc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   expire,
  input  logic   sense_h1,
  input  logic   sense_h2,
  output phase_e phase_q,
  output logic   flag_q,
  output logic   load,
  output logic   pick_green
);
  phase_e phase_d;
  logic   flag_d;
  logic   sense_act;
  logic   seq_en;

  // Flag high selects heading 1, low selects heading 2.
  assign sense_act = flag_q ? sense_h1 : sense_h2;
  assign seq_en    = expire | (phase_q == PH_DECIDE);

  always_comb begin
    phase_d    = phase_q;
    flag_d     = flag_q;
    load       = 1'b0;
    pick_green = 1'b0;
    unique case (phase_q)
      PH_AMBER: if (expire) begin
        phase_d    = PH_GO;
        flag_d     = ~flag_q;
        load       = 1'b1;
        pick_green = 1'b1;
      end
      PH_GO: if (expire) begin
        phase_d = PH_DECIDE;
        load    = 1'b1;
      end
      PH_DECIDE: begin
        phase_d = sense_act ? PH_EXTEND : PH_AMBER;
        load    = 1'b1;
      end
      PH_EXTEND: if (expire) begin
        phase_d = PH_AMBER;
        load    = 1'b1;
      end
      default: begin
        phase_d = PH_AMBER;
        load    = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_AMBER;
      flag_q  <= 1'b0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      flag_q  <= flag_d;
    end
  end

  assert_flag_swap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != $past(flag_q)) |-> ($past(phase_q) == PH_AMBER && $past(expire)));

  assert_decide_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECIDE) |=> (phase_q != PH_DECIDE));

  assert_extend_on_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECIDE && sense_act) |=> (phase_q == PH_EXTEND));

  assert_amber_on_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DECIDE && !sense_act) |=> (phase_q == PH_AMBER));
endmodule

// File: rtl/tlc_lamp_decode.sv
`timescale 1ns/1ps
module tlc_lamp_decode
  import tlc_pkg::*;
#(
  parameter int NUM_HEADINGS = 2
) (
  input  phase_e                  phase,
  input  logic                    flag,
  output lamp_t [NUM_HEADINGS-1:0] lamps
);
  for (genvar g = 0; g < NUM_HEADINGS; g++) begin : g_head
    logic active;
    // Index 0 is heading 1 (runs when flag is high), index 1 is heading 2.
    assign active = (g == 0) ? flag : ~flag;
    always_comb begin
      lamps[g].red   = ~active;
      lamps[g].amber = active & (phase == PH_AMBER);
      lamps[g].green = active & (phase != PH_AMBER);
    end
  end
endmodule

// File: rtl/xing_light_ctrl.sv
`timescale 1ns/1ps
module xing_light_ctrl
  import tlc_pkg::*;
#(
  parameter int GREEN_TICKS  = 16,
  parameter int YELLOW_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_h1,
  input  logic sense_h2,
  output logic h1_red,
  output logic h1_amber,
  output logic h1_green,
  output logic h2_red,
  output logic h2_amber,
  output logic h2_green
);
  localparam int NUM_HEADINGS = 2;
  localparam int SYNC_STAGES  = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   core_rst_n;
  logic                   expire, load, pick_green, flag;
  phase_e                 phase;
  lamp_t [NUM_HEADINGS-1:0] lamps;

  // Assert asynchronously, release after SYNC_STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[SYNC_STAGES-1];

  tlc_timer #(
    .GREEN_TICKS (GREEN_TICKS),
    .YELLOW_TICKS(YELLOW_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .load      (load),
    .pick_green(pick_green),
    .expire    (expire)
  );

  tlc_sequencer u_seq (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .expire    (expire),
    .sense_h1  (sense_h1),
    .sense_h2  (sense_h2),
    .phase_q   (phase),
    .flag_q    (flag),
    .load      (load),
    .pick_green(pick_green)
  );

  tlc_lamp_decode #(.NUM_HEADINGS(NUM_HEADINGS)) u_lamps (
    .phase(phase),
    .flag (flag),
    .lamps(lamps)
  );

  assign h1_red   = lamps[0].red;
  assign h1_amber = lamps[0].amber;
  assign h1_green = lamps[0].green;
  assign h2_red   = lamps[1].red;
  assign h2_amber = lamps[1].amber;
  assign h2_green = lamps[1].green;

  assert_one_lamp_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    ($countones({h1_red, h1_amber, h1_green}) == 1) &&
    ($countones({h2_red, h2_amber, h2_green}) == 1));

  assert_one_red_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    $countones({h1_red, h2_red}) == 1);
endmodule

// File: tb/xing_light_ctrl_bench.sv
`timescale 1ns/1ps
module xing_light_ctrl_bench;
  localparam int TG = 5;
  localparam int TY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s1 = 1'b0, s2 = 1'b0;
  logic h1r, h1y, h1g, h2r, h2y, h2g;

  int checks = 0;
  int fails = 0;
  int m_ph, m_flag, m_rem, since_rst;
  int ext_seen = 0, quiet_seen = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  xing_light_ctrl #(.GREEN_TICKS(TG), .YELLOW_TICKS(TY)) u_xing_light_ctrl (
    .clk(clk), .rst_n(rst_n), .sense_h1(s1), .sense_h2(s2),
    .h1_red(h1r), .h1_amber(h1y), .h1_green(h1g),
    .h2_red(h2r), .h2_amber(h2y), .h2_green(h2g)
  );

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s lamps got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Lamp order: h1 {red,yellow,green}, h2 {red,yellow,green}.
  function automatic logic [5:0] model_lamps();
    logic [2:0] act;
    act = (m_ph == 0) ? 3'b010 : 3'b001;
    return m_flag ? {act, 3'b100} : {3'b100, act};
  endfunction

  task automatic model_init();
    m_ph = 0; m_flag = 0; m_rem = TY; since_rst = 0;
  endtask

  task automatic model_step(input logic a1, input logic a2);
    since_rst++;
    case (m_ph)
      0: if (m_rem == 1) begin m_flag ^= 1; m_ph = 1; m_rem = TG; end else m_rem--;
      1: if (m_rem == 1) begin m_ph = 2; m_rem = TY; end else m_rem--;
      2: begin
        m_rem = TY;
        if (m_flag ? a1 : a2) begin m_ph = 3; ext_seen++; end
        else begin m_ph = 0; quiet_seen++; end
      end
      default: if (m_rem == 1) begin m_ph = 0; m_rem = TY; end else m_rem--;
    endcase
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", {h1r, h1y, h1g, h2r, h2y, h2g}, 6'b100_010);
    repeat (3) @(negedge clk);
    check("R1", {h1r, h1y, h1g, h2r, h2y, h2g}, 6'b100_010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    model_init();
  endtask

  task automatic run(input int mode, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      logic [5:0] got;
      string tag;
      got = {h1r, h1y, h1g, h2r, h2y, h2g};
      case (m_ph)
        0: tag = (since_rst < TY) ? "R1" : "R2";
        1: tag = "R3";
        2: tag = "R4";
        default: tag = "R5";
      endcase
      check(tag, got, model_lamps());
      check("R7", {1'b0, 3'($countones(got[5:3])), 2'b00, 3'($countones(got[2:0]))},
            {1'b0, 3'd1, 2'b00, 3'd1});
      check("R6", {5'b0, h1r ^ h2r}, 6'b000001);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
        0: begin s1 = 1'b0; s2 = 1'b0; end
        1: begin s1 = 1'b1; s2 = 1'b1; end
        2: begin s1 = 1'b1; s2 = 1'b0; end
        3: begin s1 = 1'b0; s2 = 1'b1; end
        default: begin s1 = lfsr[0]; s2 = lfsr[5]; end
      endcase
      model_step(s1, s2);
      @(negedge clk);
    end
  endtask

  initial begin
    apply_reset();
    for (int m = 0; m < 5; m++) run(m, 400);
    apply_reset();
    run(4, 300);
    checks++;
    if (ext_seen == 0 || quiet_seen == 0) begin
      fails++;
      $display("FAIL R4 branch coverage got ext=%0d quiet=%0d expected both nonzero",
               ext_seen, quiet_seen);
    end
    finish_run();
  end

  initial begin
    #(4 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog run did not complete got timeout expected finish");
    finish_run();
  end
endmodule